// File: doc/BRIEF.md
# Four-Channel Hit Load and Merge Sequencer

This block sits between four time-to-digital converter channels and the single encoder and zero-suppressing buffer they share. Each channel raises a hit-detect flag together with its sampled delay-line pattern. On a hit, the block holds that pattern and drops the channel's sample enable. The sampling array then stays still for one full load window, which is one slow cycle per channel. The design uses one clock, the fast sampling clock. The slow downstream clock is modelled as an enable that fires once every `RATIO` fast cycles.

A chain of load/transfer stages, one per channel, runs on the slow enable. Once every `NUM_CH` slow ticks, all stages load in parallel: each stage takes the held pattern of its own channel, marked valid only if that channel is frozen. On every other slow tick the stages shift one place toward the output end. An empty slot enters at the far end. The stage at the output end feeds a FIFO. The FIFO keeps only valid slots, each with its channel tag, and a consumer pops entries from the head.

A freeze lasts exactly `NUM_CH` slow ticks, so it always contains exactly one parallel-load tick. Every accepted hit therefore reaches the FIFO once and only once. A hit that arrives while its channel is frozen is dropped and sets a sticky per-channel flag.

Top module: `tdc_hit_merge`

## Requirements
- R1: After reset, every `sample_en_o` bit is 1, and `lost_o`, `ovf_o` and `out_valid_o` are 0.
- R2: A hit on a channel whose `sample_en_o` bit is 1 is accepted at that clock edge. The channel's `sample_en_o` bit is 0 for exactly `NUM_CH*RATIO` consecutive cycles starting at the next cycle, and the channel's `pat_i` slice at the accepting edge is the value that is later delivered.
- R3: A hit on a channel whose `sample_en_o` bit is 0 is ignored: the held pattern and the window length stay unchanged. The hit sets that channel's `lost_o` bit from the next cycle, and the bit stays set until reset.
- R4: The slow tick is every `RATIO`-th edge, counted from the first edge after reset. Every `NUM_CH`-th slow tick is a parallel load, the first one at the `RATIO`-th edge. Each accepted hit produces exactly one FIFO entry.
- R5: Between loads, the stages shift one place toward the output end on each slow tick. Hits loaded at the same load tick therefore leave in descending channel order. The tag is the channel index in binary, 0 to `NUM_CH-1`.
- R6: An empty slot (a channel that was not frozen at the load tick, or the fill at the far end of the chain) is never written to the FIFO. With no hits, `out_valid_o` stays 0.
- R7: The FIFO is first-in first-out. `out_valid_o` is 1 whenever it holds an entry, and `out_tag_o`/`out_pat_o` show the oldest entry. `pop_i` while `out_valid_o` is 1 removes that entry at the edge.
- R8: The FIFO holds `BUF_DEPTH` entries. A valid slot that reaches a full FIFO with no pop at the same edge is dropped, and `ovf_o` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_i | input | NUM_CH | Per-channel hit-detect flags |
| pat_i | input | NUM_CH*PAT_W | Per-channel sampled patterns, channel k in bits [k*PAT_W +: PAT_W] |
| pop_i | input | 1 | Remove the FIFO head |
| sample_en_o | output | NUM_CH | Per-channel sampling enable, 0 while the channel is frozen |
| lost_o | output | NUM_CH | Sticky flag: a hit arrived while the channel was frozen |
| out_valid_o | output | 1 | FIFO holds at least one entry |
| out_tag_o | output | TAG_W | Channel index of the head entry |
| out_pat_o | output | PAT_W | Pattern of the head entry |
| ovf_o | output | 1 | Sticky flag: a valid slot was dropped at a full FIFO |

## Verification
The bench builds the block with four channels, a 16-bit pattern and a fast-to-slow ratio of 4, which are the defaults. It shrinks `BUF_DEPTH` to 8, so that a burst of dense hits without pops fills the FIFO within a few frames. That makes the drop-on-full path and the sticky overflow flag reachable alongside normal draining. The short window of 16 fast cycles lets directed runs cover several things in a few hundred cycles: the exact freeze length, rejected re-hits inside the window, and four simultaneous hits leaving in descending channel order. A long random run with random pops then compares every output against the queue-based model on every cycle.

// File: rtl/tdc_merge_pkg.sv
package tdc_merge_pkg;
  localparam int unsigned DEF_NUM_CH    = 4;
  localparam int unsigned DEF_PAT_W     = 16;
  localparam int unsigned DEF_RATIO     = 4;
  localparam int unsigned DEF_BUF_DEPTH = 128;

  function automatic int unsigned safe_clog2(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/tdc_slot_timer.sv
module tdc_slot_timer
  import tdc_merge_pkg::*;
#(
  parameter int unsigned RATIO  = DEF_RATIO,
  parameter int unsigned NUM_CH = DEF_NUM_CH
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic load_o
);
  localparam int unsigned PH_W = safe_clog2(RATIO);
  localparam int unsigned SL_W = safe_clog2(NUM_CH);

  logic [PH_W-1:0] ph_q;
  logic [SL_W-1:0] sl_q;

  assign tick_o = (ph_q == PH_W'(RATIO - 1));
  assign load_o = tick_o && (sl_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      sl_q <= '0;
    end else begin
      ph_q <= tick_o ? '0 : ph_q + 1'b1;
      if (tick_o) sl_q <= (sl_q == SL_W'(NUM_CH - 1)) ? '0 : sl_q + 1'b1;
    end
  end

  p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_load_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/tdc_chan_freeze.sv
module tdc_chan_freeze
  import tdc_merge_pkg::*;
#(
  parameter int unsigned PAT_W   = DEF_PAT_W,
  parameter int unsigned FRZ_CYC = DEF_NUM_CH * DEF_RATIO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [PAT_W-1:0] pat_i,
  output logic             frozen_o,
  output logic [PAT_W-1:0] hold_o,
  output logic             lost_o
);
  localparam int unsigned CNT_W = safe_clog2(FRZ_CYC);

  logic             frozen_q, lost_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAT_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      lost_q   <= 1'b0;
      cnt_q    <= '0;
      hold_q   <= '0;
    end else if (frozen_q) begin
      if (hit_i) lost_q <= 1'b1;
      if (cnt_q == '0) frozen_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end else if (hit_i) begin
      frozen_q <= 1'b1;
      cnt_q    <= CNT_W'(FRZ_CYC - 1);
      hold_q   <= pat_i;
    end
  end

  assign frozen_o = frozen_q;
  assign hold_o   = hold_q;
  assign lost_o   = lost_q;

  p_freeze_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frozen_q && hit_i) |=> (frozen_q && hold_q == $past(pat_i)));
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |=> $stable(hold_q));
  p_lost_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |=> lost_q);
endmodule

// File: rtl/tdc_merge_chain.sv
module tdc_merge_chain
  import tdc_merge_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned PAT_W  = DEF_PAT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    load_i,
  input  logic [NUM_CH-1:0]       frozen_i,
  input  logic [NUM_CH*PAT_W-1:0] hold_i,
  output logic                    push_o,
  output logic [safe_clog2(NUM_CH)-1:0] push_tag_o,
  output logic [PAT_W-1:0]        push_pat_o
);
  localparam int unsigned TAG_W = safe_clog2(NUM_CH);
  localparam int unsigned LAST  = NUM_CH - 1;

  logic [NUM_CH-1:0] v_q;
  logic [TAG_W-1:0]  tag_q [NUM_CH];
  logic [PAT_W-1:0]  pat_q [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_stage
    logic             up_v;
    logic [TAG_W-1:0] up_tag;
    logic [PAT_W-1:0] up_pat;

    if (k == 0) begin : g_head
      assign up_v   = 1'b0;
      assign up_tag = '0;
      assign up_pat = '0;
    end else begin : g_body
      assign up_v   = v_q[k-1];
      assign up_tag = tag_q[k-1];
      assign up_pat = pat_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[k]   <= 1'b0;
        tag_q[k] <= '0;
        pat_q[k] <= '0;
      end else if (tick_i) begin
        if (load_i) begin
          v_q[k]   <= frozen_i[k];
          tag_q[k] <= TAG_W'(k);
          pat_q[k] <= hold_i[k*PAT_W +: PAT_W];
        end else begin
          v_q[k]   <= up_v;
          tag_q[k] <= up_tag;
          pat_q[k] <= up_pat;
        end
      end
    end
  end

  assign push_o     = tick_i && v_q[LAST];
  assign push_tag_o = tag_q[LAST];
  assign push_pat_o = pat_q[LAST];

  p_fill_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> !v_q[0]);
  p_shift_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (v_q[LAST] == $past(v_q[LAST-1])));
endmodule

// File: rtl/tdc_zs_fifo.sv
module tdc_zs_fifo
  import tdc_merge_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_BUF_DEPTH,
  parameter int unsigned W     = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] head_o,
  output logic         ovf_o
);
  localparam int unsigned AW = safe_clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          ovf_q;
  logic          pop_fire, push_fire, full;

  assign full      = (cnt_q == (AW+1)'(DEPTH));
  assign pop_fire  = pop_i && (cnt_q != '0);
  assign push_fire = push_i && (!full || pop_fire);

  always_ff @(posedge clk_i) begin
    if (push_fire) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_fire) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_fire)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_fire) - (AW+1)'(pop_fire);
      if (push_i && !push_fire) ovf_q <= 1'b1;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign ovf_o   = ovf_q;

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_pop_drains_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && valid_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tdc_hit_merge.sv
module tdc_hit_merge
  import tdc_merge_pkg::*;
#(
  parameter int unsigned NUM_CH    = DEF_NUM_CH,
  parameter int unsigned PAT_W     = DEF_PAT_W,
  parameter int unsigned RATIO     = DEF_RATIO,
  parameter int unsigned BUF_DEPTH = DEF_BUF_DEPTH,
  localparam int unsigned TAG_W    = safe_clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       hit_i,
  input  logic [NUM_CH*PAT_W-1:0] pat_i,
  input  logic                    pop_i,
  output logic [NUM_CH-1:0]       sample_en_o,
  output logic [NUM_CH-1:0]       lost_o,
  output logic                    out_valid_o,
  output logic [TAG_W-1:0]        out_tag_o,
  output logic [PAT_W-1:0]        out_pat_o,
  output logic                    ovf_o
);
  localparam int unsigned FRZ_CYC = NUM_CH * RATIO;
  localparam int unsigned ENT_W   = TAG_W + PAT_W;

  logic                    tick, load;
  logic [NUM_CH-1:0]       frozen;
  logic [NUM_CH*PAT_W-1:0] hold;
  logic                    push;
  logic [TAG_W-1:0]        push_tag;
  logic [PAT_W-1:0]        push_pat;
  logic [ENT_W-1:0]        head;

  tdc_slot_timer #(.RATIO(RATIO), .NUM_CH(NUM_CH)) u_timer (
    .clk_i, .rst_ni, .tick_o(tick), .load_o(load)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    tdc_chan_freeze #(.PAT_W(PAT_W), .FRZ_CYC(FRZ_CYC)) u_frz (
      .clk_i, .rst_ni,
      .hit_i   (hit_i[k]),
      .pat_i   (pat_i[k*PAT_W +: PAT_W]),
      .frozen_o(frozen[k]),
      .hold_o  (hold[k*PAT_W +: PAT_W]),
      .lost_o  (lost_o[k])
    );
  end

  assign sample_en_o = ~frozen;

  tdc_merge_chain #(.NUM_CH(NUM_CH), .PAT_W(PAT_W)) u_chain (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .load_i    (load),
    .frozen_i  (frozen),
    .hold_i    (hold),
    .push_o    (push),
    .push_tag_o(push_tag),
    .push_pat_o(push_pat)
  );

  tdc_zs_fifo #(.DEPTH(BUF_DEPTH), .W(ENT_W)) u_buf (
    .clk_i, .rst_ni,
    .push_i     (push),
    .push_data_i({push_tag, push_pat}),
    .pop_i,
    .valid_o    (out_valid_o),
    .head_o     (head),
    .ovf_o
  );

  assign {out_tag_o, out_pat_o} = head;

  p_lost_needs_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lost_o[0])) |-> $past(!sample_en_o[0]));
endmodule

// File: tb/tb_tdc_hit_merge.sv
module tb_tdc_hit_merge;
  localparam int NCH = 4;
  localparam int PW  = 16;
  localparam int RAT = 4;
  localparam int DEP = 8;
  localparam int FRZ = NCH * RAT;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0]    hit_i = '0;
  logic [NCH*PW-1:0] pat_i = '0;
  logic              pop_i = 1'b0;
  logic [NCH-1:0]    sample_en_o, lost_o;
  logic              out_valid_o, ovf_o;
  logic [1:0]        out_tag_o;
  logic [PW-1:0]     out_pat_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_hit_merge #(.NUM_CH(NCH), .PAT_W(PW), .RATIO(RAT), .BUF_DEPTH(DEP)) dut (
    .clk_i(clk), .rst_ni, .hit_i, .pat_i, .pop_i,
    .sample_en_o, .lost_o, .out_valid_o, .out_tag_o, .out_pat_o, .ovf_o
  );

  // reference model
  int          m_ph, m_sl;
  int          m_frz [NCH];
  logic [PW-1:0] m_hold [NCH];
  bit          m_lost [NCH];
  bit          m_v [NCH];
  int          m_tag [NCH];
  logic [PW-1:0] m_pat [NCH];
  bit          m_ovf;
  int          q_tag [$];
  logic [PW-1:0] q_pat [$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_sl = 0; m_ovf = 0;
      for (int k = 0; k < NCH; k++) begin
        m_frz[k] = 0; m_hold[k] = '0; m_lost[k] = 0;
        m_v[k] = 0; m_tag[k] = 0; m_pat[k] = '0;
      end
      q_tag.delete(); q_pat.delete();
    end else begin
      if (pop_i && q_tag.size() > 0) begin
        void'(q_tag.pop_front()); void'(q_pat.pop_front());
      end
      if (m_ph == RAT-1) begin
        if (m_v[NCH-1]) begin
          if (q_tag.size() < DEP) begin
            q_tag.push_back(m_tag[NCH-1]); q_pat.push_back(m_pat[NCH-1]);
          end else m_ovf = 1;
        end
        if (m_sl == 0) begin
          for (int k = 0; k < NCH; k++) begin
            m_v[k] = (m_frz[k] > 0); m_tag[k] = k; m_pat[k] = m_hold[k];
          end
        end else begin
          for (int k = NCH-1; k > 0; k--) begin
            m_v[k] = m_v[k-1]; m_tag[k] = m_tag[k-1]; m_pat[k] = m_pat[k-1];
          end
          m_v[0] = 0;
        end
        m_sl = (m_sl + 1) % NCH;
      end
      m_ph = (m_ph + 1) % RAT;
      for (int k = 0; k < NCH; k++) begin
        if (m_frz[k] > 0) begin
          if (hit_i[k]) m_lost[k] = 1;
          m_frz[k]--;
        end else if (hit_i[k]) begin
          m_frz[k] = FRZ;
          m_hold[k] = pat_i[k*PW +: PW];
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && chk_on) begin
      logic [NCH-1:0] en_e, lost_e;
      for (int k = 0; k < NCH; k++) begin
        en_e[k] = (m_frz[k] == 0); lost_e[k] = m_lost[k];
      end
      check(sample_en_o == en_e, "R2", "sample_en_o", sample_en_o, en_e);
      check(lost_o == lost_e, "R3", "lost_o", lost_o, lost_e);
      check(out_valid_o == (q_tag.size() > 0), "R7", "out_valid_o",
            out_valid_o, q_tag.size() > 0);
      if (q_tag.size() > 0 && out_valid_o)
        check(out_tag_o == q_tag[0] && out_pat_o == q_pat[0], "R5", "head tag/pat",
              {out_tag_o, out_pat_o}, {q_tag[0][1:0], q_pat[0]});
      check(ovf_o == m_ovf, "R8", "ovf_o", ovf_o, m_ovf);
    end
  end

  function automatic logic [PW-1:0] pat_of(input logic [PW-1:0] base, input int k);
    return base ^ PW'(k * 16'h0101);
  endfunction

  task automatic drive_hits(input logic [NCH-1:0] mask, input logic [PW-1:0] base);
    @(negedge clk); #1;
    hit_i = mask;
    for (int k = 0; k < NCH; k++) pat_i[k*PW +: PW] = pat_of(base, k);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    hit_i = '0; pop_i = 1'b0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pop_expect(input int tag, input logic [PW-1:0] pat, input string req);
    @(negedge clk); #1;
    hit_i = '0;
    check(out_valid_o == 1'b1, req, "valid before pop", out_valid_o, 1);
    check(out_tag_o == tag[1:0], req, "popped tag", out_tag_o, tag);
    check(out_pat_o == pat, req, "popped pattern", out_pat_o, pat);
    pop_i = 1'b1;
    @(negedge clk); #1;
    pop_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int low;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sample_en_o == '1, "R1", "sample_en_o", sample_en_o, 4'hf);
    check(lost_o == '0, "R1", "lost_o", lost_o, 0);
    check(!out_valid_o, "R1", "out_valid_o", out_valid_o, 0);
    check(!ovf_o, "R1", "ovf_o", ovf_o, 0);
    chk_on = 1;

    // R2 exact window length
    drive_hits(4'b0001, 16'hA5A5);
    low = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sample_en_o[0]) low++;
      #1 hit_i = '0;
    end
    check(low == FRZ, "R2", "frozen cycles", low, FRZ);
    pop_expect(0, pat_of(16'hA5A5, 0), "R4");
    idle(2);
    check(!out_valid_o, "R4", "single entry per hit", out_valid_o, 0);

    // R3 re-hit inside window
    drive_hits(4'b0100, 16'h1110);
    idle(3);
    drive_hits(4'b0100, 16'h2220);
    idle(1);
    check(lost_o[2] == 1'b1, "R3", "lost_o[2]", lost_o[2], 1);
    idle(40);
    pop_expect(2, pat_of(16'h1110, 2), "R3");
    idle(2);
    check(!out_valid_o, "R3", "ignored hit gave no entry", out_valid_o, 0);

    // R5 simultaneous hits leave in descending channel order
    drive_hits(4'b1111, 16'h5A00);
    idle(40);
    for (int k = NCH-1; k >= 0; k--) pop_expect(k, pat_of(16'h5A00, k), "R5");

    // R6 no hits -> nothing buffered
    idle(60);
    check(!out_valid_o, "R6", "idle out_valid_o", out_valid_o, 0);
    check(lost_o == 4'b0100, "R3", "lost sticky", lost_o, 4'b0100);

    // random traffic with random pops (R4, R7)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      for (int k = 0; k < NCH; k++) begin
        hit_i[k] = ($urandom_range(0, 9) == 0);
        pat_i[k*PW +: PW] = PW'($urandom);
      end
      pop_i = ($urandom_range(0, 1) == 1);
    end

    // dense hits with no pops (R8)
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      hit_i = '1; pop_i = 1'b0;
      for (int k = 0; k < NCH; k++) pat_i[k*PW +: PW] = PW'(i * 4 + k);
    end
    idle(1);
    check(ovf_o == 1'b1, "R8", "ovf after burst", ovf_o, 1);

    // drain (R7)
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      hit_i = '0; pop_i = 1'b1;
    end
    idle(2);
    check(!out_valid_o, "R7", "drained", out_valid_o, 0);
    check(ovf_o == 1'b1, "R8", "ovf sticky", ovf_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule